// File: doc/BRIEF.md
# Sector-Synchronized Reference Current Generator

This block is the fixed-point command path of a three-phase shunt compensator. Each sample it receives three signed load-current readings, three phase-voltage readings, the dc bus voltage and three unit templates, one for each phase. From these it forms three signed compensator command currents. A sector strobe arrives six times per mains cycle and marks the edges of sixty-degree sectors.

Within a sector the block sums the instantaneous load power (va·ia + vb·ib + vc·ic) into an energy accumulator. It also sums the bus-voltage samples. When the strobe arrives, it turns both sums into one peak supply current for the sector that is starting:

- An active term comes from the energy. It uses a precomputed reciprocal of 1.5 × peak phase voltage × sector length.
- A bus-recovery term comes from the squared difference between a reference bus voltage and the measured average bus voltage.

All scaling uses constant multipliers and arithmetic shifts, so no divider is needed. Each sample, the block multiplies every template by the peak and subtracts that phase's load current to give the command.

Top module: `sector_refgen`

## Requirements
- R1: While `rst_n` is low, `peak`, all three commands and `cmd_vld` are zero.
- R2: On each cycle with `smp_vld` high, the energy accumulator adds va·ia + vb·ib + vc·ic. The active term at a strobe is floor(E·K_P / 2^SH).
- R3: The bus-recovery term at a strobe is floor((VREF² − Vavg²)·K_B / 2^SH), where Vavg = floor(S·K_AVG / 2^SH), S is the sector's bus-sample sum and K_AVG = floor(2^SH / N_SECT).
- R4: On a cycle with `sect_stb` high, `peak` loads the sum of the active and bus terms, clamped to a signed PW-bit range. On all other cycles `peak` keeps its value.
- R5: The first strobe after reset leaves `peak` at zero, because the sector before it is incomplete. Only the second and later strobes load a computed value.
- R6: A strobe restarts both accumulators. A sample that arrives in the strobe cycle counts as the first sample of the new sector. A strobe without a sample leaves both accumulators at zero.
- R7: One cycle after a sample, each command equals floor(peak·template / 2^(TW−1)) − load current of that phase, and `cmd_vld` is high. A template is signed with TW−1 fraction bits, so 2^(TW−1) stands for 1.0. `cmd_vld` is low one cycle after a cycle without a sample.
- R8: A sample that arrives in a strobe cycle is scaled by the newly computed peak, not by the previous one.
- R9: The peak and the commands clamp to their signed output widths instead of wrapping. Defaults: peak 16 bits, commands 16 bits.
- R10: The commands hold their values across cycles with no sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | A new set of readings is present |
| sect_stb | input | 1 | Sector boundary, six per mains cycle |
| ild_a | input | DW | Phase A load current, signed |
| ild_b | input | DW | Phase B load current, signed |
| ild_c | input | DW | Phase C load current, signed |
| vph_a | input | DW | Phase A voltage, signed |
| vph_b | input | DW | Phase B voltage, signed |
| vph_c | input | DW | Phase C voltage, signed |
| vdc | input | DW | DC bus voltage, signed |
| tpl_a | input | TW | Phase A unit template, signed, TW−1 fraction bits |
| tpl_b | input | TW | Phase B unit template |
| tpl_c | input | TW | Phase C unit template |
| peak | output | PW | Peak supply current for the current sector |
| cmd_a | output | OW | Phase A command current |
| cmd_b | output | OW | Phase B command current |
| cmd_c | output | OW | Phase C command current |
| cmd_vld | output | 1 | Commands were updated at the last edge |

## Verification
Errors inside a sector stay hidden until the sector closes. A wrong energy or bus sum, or a sample counted into the wrong sector, changes nothing at the ports until the next strobe. From that edge on, it shows as a wrong `peak` and as wrong scaling on every command for the whole following sector. A wrong choice between the old and new peak shows only on commands that follow a strobe-cycle sample, and it shows one cycle later. A cycle-by-cycle model therefore compares `peak` and the commands on every clock, and directed sectors pin the active term and the bus term separately. Additional sectors drive both terms into clamping, in both the positive and the negative direction.

// File: rtl/sector_refgen.sv
module sector_refgen #(
  parameter int DW     = 12,
  parameter int TW     = 12,
  parameter int PW     = 16,
  parameter int OW     = 16,
  parameter int AW     = 48,
  parameter int SH     = 16,
  parameter int N_SECT = 32,
  parameter int VREF   = 1500,
  parameter int K_P    = 20,
  parameter int K_B    = 4096
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic                 sect_stb,
  input  logic signed [DW-1:0] ild_a,
  input  logic signed [DW-1:0] ild_b,
  input  logic signed [DW-1:0] ild_c,
  input  logic signed [DW-1:0] vph_a,
  input  logic signed [DW-1:0] vph_b,
  input  logic signed [DW-1:0] vph_c,
  input  logic signed [DW-1:0] vdc,
  input  logic signed [TW-1:0] tpl_a,
  input  logic signed [TW-1:0] tpl_b,
  input  logic signed [TW-1:0] tpl_c,
  output logic signed [PW-1:0] peak,
  output logic signed [OW-1:0] cmd_a,
  output logic signed [OW-1:0] cmd_b,
  output logic signed [OW-1:0] cmd_c,
  output logic                 cmd_vld
);
  typedef logic signed [63:0] w_t;
  localparam int K_AVG = (1 << SH) / N_SECT;
  localparam int TSH   = TW - 1;

  function automatic w_t clamp(input w_t x, input int w);
    w_t hi, lo;
    hi = (w_t'(1) <<< (w - 1)) - w_t'(1);
    lo = -hi - w_t'(1);
    return (x > hi) ? hi : ((x < lo) ? lo : x);
  endfunction

  logic signed [DW-1:0] ild [3];
  logic signed [TW-1:0] tpl [3];
  logic signed [OW-1:0] cmd [3];
  assign ild[0] = ild_a;
  assign ild[1] = ild_b;
  assign ild[2] = ild_c;
  assign tpl[0] = tpl_a;
  assign tpl[1] = tpl_b;
  assign tpl[2] = tpl_c;

  logic signed [AW-1:0] e_acc, v_sum;
  logic signed [PW-1:0] peak_q, pk_new, pk_use;
  logic                 seen;
  w_t p_now, v_avg, i_act, i_bus, raw;

  assign p_now = w_t'(vph_a) * w_t'(ild_a) + w_t'(vph_b) * w_t'(ild_b)
               + w_t'(vph_c) * w_t'(ild_c);
  assign v_avg = (w_t'(v_sum) * w_t'(K_AVG)) >>> SH;
  assign i_act = (w_t'(e_acc) * w_t'(K_P)) >>> SH;
  assign i_bus = ((w_t'(VREF) * w_t'(VREF) - v_avg * v_avg) * w_t'(K_B)) >>> SH;
  assign raw   = i_act + i_bus;
  assign pk_new = seen ? PW'(clamp(raw, PW)) : '0;
  assign pk_use = sect_stb ? pk_new : peak_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_acc   <= '0;
      v_sum   <= '0;
      peak_q  <= '0;
      seen    <= 1'b0;
      cmd_vld <= 1'b0;
    end else begin
      cmd_vld <= smp_vld;
      if (sect_stb) begin
        seen   <= 1'b1;
        peak_q <= pk_new;
        e_acc  <= smp_vld ? AW'(p_now) : '0;
        v_sum  <= smp_vld ? AW'(vdc) : '0;
      end else if (smp_vld) begin
        e_acc <= e_acc + AW'(p_now);
        v_sum <= v_sum + AW'(vdc);
      end
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_ph
    w_t diff;
    assign diff = ((w_t'(pk_use) * w_t'(tpl[g])) >>> TSH) - w_t'(ild[g]);
    always_ff @(posedge clk) begin
      if (!rst_n)       cmd[g] <= '0;
      else if (smp_vld) cmd[g] <= OW'(clamp(diff, OW));
    end
  end

  assign peak  = peak_q;
  assign cmd_a = cmd[0];
  assign cmd_b = cmd[1];
  assign cmd_c = cmd[2];
endmodule

module sector_refgen_chk #(
  parameter int DW = 12,
  parameter int PW = 16,
  parameter int OW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_vld,
  input logic                 sect_stb,
  input logic signed [DW-1:0] ild_a,
  input logic signed [PW-1:0] peak,
  input logic signed [OW-1:0] cmd_a,
  input logic signed [OW-1:0] cmd_b,
  input logic signed [OW-1:0] cmd_c,
  input logic                 cmd_vld
);
  logic [1:0] nstb;
  always_ff @(posedge clk) begin
    if (!rst_n)                     nstb <= 2'd0;
    else if (sect_stb && nstb != 2'd2) nstb <= nstb + 2'd1;
  end

  // R4
  peak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sect_stb |=> $stable(peak));

  // R5
  peak_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nstb != 2'd2) |-> (peak == '0));

  // R7
  vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> cmd_vld);

  // R7
  vld_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> !cmd_vld);

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> ($stable(cmd_a) && $stable(cmd_b) && $stable(cmd_c)));

  // R7
  zero_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !sect_stb && peak == '0) |=> (int'(cmd_a) == -int'($past(ild_a))));
endmodule

bind sector_refgen sector_refgen_chk #(.DW(DW), .PW(PW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .sect_stb(sect_stb),
  .ild_a(ild_a), .peak(peak), .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_c(cmd_c),
  .cmd_vld(cmd_vld));

// File: tb/sim_sector_refgen.sv
`timescale 1ns/1ps
module sim_sector_refgen;
  localparam int DW = 12, TW = 12, PW = 16, OW = 16;
  localparam int SH = 16, N_SECT = 32, VREF = 1500, K_P = 20, K_B = 4096;

  logic clk = 1'b0, rst_n = 1'b0, smp_vld = 1'b0, sect_stb = 1'b0;
  logic signed [DW-1:0] il [3];
  logic signed [DW-1:0] vp [3];
  logic signed [TW-1:0] tp [3];
  logic signed [DW-1:0] vdc;
  logic signed [PW-1:0] peak;
  logic signed [OW-1:0] cmd [3];
  logic cmd_vld;

  int nx_il [3];
  int nx_vp [3];
  int nx_tp [3];
  int nx_vdc;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  sector_refgen u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .sect_stb(sect_stb),
    .ild_a(il[0]), .ild_b(il[1]), .ild_c(il[2]),
    .vph_a(vp[0]), .vph_b(vp[1]), .vph_c(vp[2]), .vdc(vdc),
    .tpl_a(tp[0]), .tpl_b(tp[1]), .tpl_c(tp[2]),
    .peak(peak), .cmd_a(cmd[0]), .cmd_b(cmd[1]), .cmd_c(cmd[2]),
    .cmd_vld(cmd_vld));

  function automatic longint sat(input longint x, input int w);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    if (x > hi) return hi;
    if (x < -hi - 1) return -hi - 1;
    return x;
  endfunction

  // behavioural reference model
  longint m_e, m_vs, m_pk, m_cmd [3];
  bit m_cv, m_seen, m_lsv, m_lstb;
  int m_nstb;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_e = 0; m_vs = 0; m_pk = 0; m_cv = 0; m_seen = 0; m_nstb = 0;
      m_lsv = 0; m_lstb = 0;
      for (int k = 0; k < 3; k++) m_cmd[k] = 0;
    end else begin
      longint pu, p;
      pu = m_pk;
      if (sect_stb) begin
        longint avg, act, bus;
        avg = (m_vs * ((1 << SH) / N_SECT)) >>> SH;
        act = (m_e * K_P) >>> SH;
        bus = ((longint'(VREF) * VREF - avg * avg) * K_B) >>> SH;
        pu = m_seen ? sat(act + bus, PW) : 0;
        m_seen = 1;
        if (m_nstb < 2) m_nstb++;
      end
      p = 0;
      for (int k = 0; k < 3; k++) p += longint'(vp[k]) * longint'(il[k]);
      if (smp_vld)
        for (int k = 0; k < 3; k++)
          m_cmd[k] = sat(((pu * longint'(tp[k])) >>> (TW - 1)) - longint'(il[k]), OW);
      if (sect_stb) begin
        m_e  = smp_vld ? p : 0;
        m_vs = smp_vld ? longint'(vdc) : 0;
      end else if (smp_vld) begin
        m_e  += p;
        m_vs += longint'(vdc);
      end
      m_pk = pu; m_cv = smp_vld; m_lsv = smp_vld; m_lstb = sect_stb;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic compare();
    string tg;
    tg = (m_nstb < 2) ? "R5 peak" : "R4 R6 peak";
    if (m_pk == 32767 || m_pk == -32768) tg = {tg, " R9"};
    chk(tg, peak, m_pk);
    chk("R7 cmd_vld", cmd_vld, m_cv);
    for (int k = 0; k < 3; k++) begin
      tg = !m_lsv ? "R10 cmd" : (m_lstb ? "R8 cmd" : "R7 cmd");
      if (m_cmd[k] == 32767 || m_cmd[k] == -32768) tg = {tg, " R9"};
      chk($sformatf("%s[%0d]", tg, k), cmd[k], m_cmd[k]);
    end
  endtask

  task automatic drive(input bit sv, input bit stb);
    @(negedge clk);
    compare();
    smp_vld = sv; sect_stb = stb; vdc = DW'(nx_vdc);
    for (int k = 0; k < 3; k++) begin
      il[k] = DW'(nx_il[k]); vp[k] = DW'(nx_vp[k]); tp[k] = TW'(nx_tp[k]);
    end
  endtask

  function automatic int rnd(input int lo, input int hi);
    return lo + int'($urandom_range(hi - lo));
  endfunction

  task automatic rand_tp();
    for (int k = 0; k < 3; k++) nx_tp[k] = rnd(-2048, 2047);
  endtask

  // one full sector of N_SECT samples, strobe on the first
  task automatic run_sector(input int mode);
    for (int s = 0; s < N_SECT; s++) begin
      rand_tp();
      if (mode == 0) begin
        for (int k = 0; k < 3; k++) begin
          nx_il[k] = rnd(-600, 600); nx_vp[k] = rnd(-1500, 1500);
        end
        nx_vdc = rnd(1400, 1600);
      end
      drive(1'b1, s == 0);
    end
  endtask

  task automatic close_and_idle();
    drive(1'b1, 1'b1);
    drive(1'b0, 1'b0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      il[k] = '0; vp[k] = '0; tp[k] = '0; nx_il[k] = 0; nx_vp[k] = 0; nx_tp[k] = 0;
    end
    vdc = '0; nx_vdc = 0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 peak", peak, 0);
    chk("R1 cmd_vld", cmd_vld, 0);
    for (int k = 0; k < 3; k++) chk("R1 cmd", cmd[k], 0);
    rst_n = 1'b1;

    // first sector after reset must not load
    run_sector(0);
    drive(1'b0, 1'b0);
    chk("R5 first strobe", peak, 0);
    for (int n = 0; n < 5; n++) run_sector(0);

    // R2 active term only: bus at reference, one phase loaded
    nx_vp[0] = 1000; nx_il[0] = 100; nx_vp[1] = 0; nx_il[1] = 0;
    nx_vp[2] = 0; nx_il[2] = 0; nx_vdc = VREF;
    for (int n = 0; n < 2; n++) run_sector(1);
    close_and_idle();
    chk("R2 active peak", peak, 976);

    // R3 bus term only: no load current, bus 100 below reference
    for (int k = 0; k < 3; k++) begin nx_il[k] = 0; nx_vp[k] = 700; end
    nx_vdc = VREF - 100;
    for (int n = 0; n < 2; n++) run_sector(1);
    close_and_idle();
    chk("R3 bus peak", peak, 18125);

    // R9 positive clamp: bus collapsed, full-scale templates
    nx_vdc = 0;
    run_sector(1);
    for (int n = 0; n < 2; n++) begin
      for (int s = 0; s < N_SECT; s++) begin
        for (int k = 0; k < 3; k++) begin
          nx_tp[k] = (s % 2) ? 2047 : -2048; nx_il[k] = rnd(-2048, 2047);
        end
        drive(1'b1, s == 0);
      end
    end
    close_and_idle();
    chk("R9 peak high clamp", peak, 32767);

    // R9 negative clamp: bus far above reference
    nx_vdc = 2000;
    for (int n = 0; n < 2; n++) run_sector(1);
    close_and_idle();
    chk("R9 peak low clamp", peak, -32768);

    // irregular samples and strobes, including strobes without samples
    for (int i = 0; i < 800; i++) begin
      bit sv, stb;
      for (int k = 0; k < 3; k++) begin
        nx_il[k] = rnd(-800, 800); nx_vp[k] = rnd(-1500, 1500);
      end
      rand_tp();
      nx_vdc = rnd(1300, 1700);
      sv  = ($urandom_range(9) < 7);
      stb = ($urandom_range(39) == 0);
      drive(sv, stb);
    end
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule